// File: doc/BRIEF.md
# Time-of-Day Alarm, Watchdog and Interrupt Pin Controller

This block watches the running time of day and raises a time-of-day event when the programmed minutes, hours and weekday match. Per-field mask bits widen the match to a daily, hourly or once-a-minute event. Beside the alarm sits a four-digit BCD countdown watchdog. It counts down in hundredths of a second and is restarted whenever software touches its period bytes. Each source sets its own flag. A control byte picks which of the two sources drives a single interrupt pin, gates each source with a mask, sets the pin's active polarity and chooses between a held level and a timed pulse.

The time counters sit outside the block. They present BCD seconds, minutes, hours and weekday, together with a 100 Hz tick on which those values are sampled. A 1 kHz tick times the pulse mode. Software reaches six byte registers over a simple select/write bus with a combinational read port.

Top module: `tod_wdog_irq`

## Requirements
- R1: After reset every register reads 0, both flags are 0 and the pin is released (irq_oe_o=0, irq_o=0). Register index: 0 alarm minutes, 1 alarm hours, 2 alarm weekday, 3 watchdog hundredths, 4 watchdog seconds, 5 control. The weekday byte keeps only bit 7 and bits 2:0, and its other bits read 0.
- R2: With no alarm mask set (bit 7 of bytes 0..2 clear), the time-of-day flag (control bit 0) sets on the 100 Hz tick where minutes, hours and weekday first all match. It does not set again while the match persists.
- R3: Mask bit on the weekday byte alone gives a daily alarm that ignores the weekday. Mask bits on weekday and hours give an hourly alarm that compares minutes only.
- R4: With all three mask bits set, the alarm fires on the tick where the seconds input reads 00.
- R5: Any read or write of bytes 0..2 clears the time-of-day flag and its pending interrupt.
- R6: The watchdog flag (control bit 1) sets on the N-th 100 Hz tick after the last watchdog access, where N is the BCD value {byte 4, byte 3}. Reads of bytes 3 and 4 return the stored value.
- R7: Any read or write of byte 3 or 4 clears the watchdog flag and restarts the countdown from the full period.
- R8: A period of 0000 disables the watchdog: its flag never sets.
- R9: Control bit 6 selects the pin source: 1 selects the watchdog, 0 the time-of-day alarm. Control bit 3 (watchdog) and bit 2 (time of day) mask a source from the pin without stopping its flag from setting.
- R10: While the interrupt is active, irq_oe_o=1 and irq_o equals control bit 5: 1 drives high, 0 pulls low. While it is inactive the pin is released.
- R11: With control bit 4 clear, the flag and pin hold until cleared by an access. With bit 4 set, the flag and pin clear on the fourth 1 kHz tick after the event (3 ms to 4 ms).
- R12: The pin becomes active at the same clock edge that samples the alarm tick or the watchdog expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_100hz_i | input | 1 | One-cycle strobe each 10 ms; time inputs are valid with it |
| tick_1khz_i | input | 1 | One-cycle strobe each 1 ms, times the pulse mode |
| cur_sec_i | input | 8 | Current seconds, BCD |
| cur_min_i | input | 8 | Current minutes, BCD |
| cur_hr_i | input | 8 | Current hours, BCD including 12/24 and PM bits |
| cur_day_i | input | 8 | Current weekday, 1..7 |
| sel_i | input | 1 | Register access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Value driven on the interrupt pin |
| irq_oe_o | output | 1 | Drive enable of the interrupt pin |

## Verification
The hardest case to reach is the watchdog borrow across all four BCD digits together with the exact expiry tick. A period of 01.00 is loaded and exactly 100 single-cycle ticks are applied, with the flag checked after tick 99 and again after tick 100. The no-refire rule is also awkward to reach, because it needs a persisting match after the flag has been cleared. The bench clears the flag with a plain read of an alarm byte, which leaves the match history intact, then ticks again with unchanged time inputs. Pulse release is checked by counting 1 kHz strobes one at a time around the fourth.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  localparam int unsigned REG_AW    = 3;
  localparam int unsigned WD_DIGITS = 4;
  localparam int unsigned PULSE_MS  = 3;

  typedef enum logic [REG_AW-1:0] {
    REG_ALM_MIN = 3'd0,
    REG_ALM_HR  = 3'd1,
    REG_ALM_DAY = 3'd2,
    REG_WD_LO   = 3'd3,
    REG_WD_HI   = 3'd4,
    REG_CTRL    = 3'd5
  } reg_addr_e;

  // control byte bit positions
  localparam int unsigned CB_WD_SEL   = 6;
  localparam int unsigned CB_POL      = 5;
  localparam int unsigned CB_PULSE    = 4;
  localparam int unsigned CB_WD_MASK  = 3;
  localparam int unsigned CB_TOD_MASK = 2;

  localparam int unsigned SRC_TOD = 0;
  localparam int unsigned SRC_WD  = 1;
  localparam int unsigned N_SRC   = 2;
endpackage

// File: rtl/tdw_alarm_match.sv
module tdw_alarm_match (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rearm_i,
  input  logic [7:0] cur_sec_i,
  input  logic [7:0] cur_min_i,
  input  logic [7:0] cur_hr_i,
  input  logic [7:0] cur_day_i,
  input  logic [7:0] alm_min_i,
  input  logic [7:0] alm_hr_i,
  input  logic [3:0] alm_day_i,
  output logic       fire_o
);
  logic mask_all, min_ok, hr_ok, day_ok, match, match_q;

  assign mask_all = alm_min_i[7] & alm_hr_i[7] & alm_day_i[3];
  assign min_ok   = alm_min_i[7] | (cur_min_i == {1'b0, alm_min_i[6:0]});
  assign hr_ok    = alm_hr_i[7]  | (cur_hr_i  == {1'b0, alm_hr_i[6:0]});
  assign day_ok   = alm_day_i[3] | (cur_day_i == {5'b0, alm_day_i[2:0]});
  assign match    = mask_all ? (cur_sec_i == 8'h00) : (min_ok & hr_ok & day_ok);

  // match history: fire only on first tick of a match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      match_q <= 1'b0;
    else if (rearm_i) match_q <= 1'b0;
    else if (tick_i)  match_q <= match;
  end

  assign fire_o = tick_i & match & ~match_q;
endmodule

// File: rtl/tdw_wdog.sv
module tdw_wdog #(
  parameter int unsigned DIGITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                reload_i,
  input  logic [4*DIGITS-1:0] period_i,
  output logic                expire_o
);
  localparam int unsigned W = 4 * DIGITS;

  logic [W-1:0]    cnt_q, cnt_dec;
  logic [DIGITS:0] brw;
  logic            cnt_zero, cnt_last;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] d;
    assign d = cnt_q[4*g +: 4];
    assign cnt_dec[4*g +: 4] = !brw[g] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
    assign brw[g+1] = brw[g] & (d == 4'd0);
  end

  assign cnt_zero = brw[DIGITS];
  assign cnt_last = (cnt_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (reload_i)            cnt_q <= period_i;
    else if (tick_i && !cnt_zero) cnt_q <= cnt_dec;
  end

  assign expire_o = tick_i & ~reload_i & cnt_last;
endmodule

// File: rtl/tdw_flag_unit.sv
module tdw_flag_unit #(
  parameter int unsigned PULSE_MS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic pulse_mode_i,
  input  logic ms_tick_i,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(PULSE_MS + 2);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      cnt_q  <= '0;
    end else if (set_i) begin
      flag_o <= 1'b1;
      cnt_q  <= '0;
    end else if (clr_i) begin
      flag_o <= 1'b0;
      cnt_q  <= '0;
    end else if (flag_o && pulse_mode_i && ms_tick_i) begin
      if (cnt_q == CW'(PULSE_MS)) begin
        flag_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tod_wdog_irq.sv
module tod_wdog_irq
  import tdw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_100hz_i,
  input  logic       tick_1khz_i,
  input  logic [7:0] cur_sec_i,
  input  logic [7:0] cur_min_i,
  input  logic [7:0] cur_hr_i,
  input  logic [7:0] cur_day_i,
  input  logic       sel_i,
  input  logic       wr_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       irq_oe_o
);
  localparam int unsigned PW = 4 * WD_DIGITS;

  logic [7:0]    alm_min_q, alm_hr_q, wd_lo_q, wd_hi_q;
  logic [3:0]    alm_day_q;
  logic [7:2]    ctl_q;
  logic          acc_alarm, acc_wd, wr_en;
  logic [PW-1:0] period_nxt;
  logic          tod_fire, wd_expire;
  logic [N_SRC-1:0] src_set, src_clr, flag_q;
  logic          tod_flag, wd_flag, active;

  assign wr_en     = sel_i & wr_i;
  assign acc_alarm = sel_i & ((addr_i == REG_ALM_MIN) | (addr_i == REG_ALM_HR) |
                              (addr_i == REG_ALM_DAY));
  assign acc_wd    = sel_i & ((addr_i == REG_WD_LO) | (addr_i == REG_WD_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_min_q <= '0;
      alm_hr_q  <= '0;
      alm_day_q <= '0;
      wd_lo_q   <= '0;
      wd_hi_q   <= '0;
      ctl_q     <= '0;
    end else if (wr_en) begin
      case (addr_i)
        REG_ALM_MIN: alm_min_q <= wdata_i;
        REG_ALM_HR:  alm_hr_q  <= wdata_i;
        REG_ALM_DAY: alm_day_q <= {wdata_i[7], wdata_i[2:0]};
        REG_WD_LO:   wd_lo_q   <= wdata_i;
        REG_WD_HI:   wd_hi_q   <= wdata_i;
        REG_CTRL:    ctl_q     <= wdata_i[7:2];
        default: ;
      endcase
    end
  end

  // reload value includes a write landing in this cycle
  always_comb begin
    period_nxt = {wd_hi_q, wd_lo_q};
    if (wr_en && addr_i == REG_WD_LO) period_nxt[7:0]  = wdata_i;
    if (wr_en && addr_i == REG_WD_HI) period_nxt[15:8] = wdata_i;
  end

  tdw_alarm_match u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_100hz_i),
    .rearm_i   (acc_alarm & wr_i),
    .cur_sec_i (cur_sec_i),
    .cur_min_i (cur_min_i),
    .cur_hr_i  (cur_hr_i),
    .cur_day_i (cur_day_i),
    .alm_min_i (alm_min_q),
    .alm_hr_i  (alm_hr_q),
    .alm_day_i (alm_day_q),
    .fire_o    (tod_fire)
  );

  tdw_wdog #(.DIGITS(WD_DIGITS)) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_100hz_i),
    .reload_i (acc_wd),
    .period_i (period_nxt),
    .expire_o (wd_expire)
  );

  assign src_set[SRC_TOD] = tod_fire;
  assign src_clr[SRC_TOD] = acc_alarm;
  assign src_set[SRC_WD]  = wd_expire;
  assign src_clr[SRC_WD]  = acc_wd;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    tdw_flag_unit #(.PULSE_MS(PULSE_MS)) u_flag (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .set_i        (src_set[s]),
      .clr_i        (src_clr[s]),
      .pulse_mode_i (ctl_q[CB_PULSE]),
      .ms_tick_i    (tick_1khz_i),
      .flag_o       (flag_q[s])
    );
  end

  assign tod_flag = flag_q[SRC_TOD];
  assign wd_flag  = flag_q[SRC_WD];

  assign active   = ctl_q[CB_WD_SEL] ? (wd_flag  & ~ctl_q[CB_WD_MASK])
                                     : (tod_flag & ~ctl_q[CB_TOD_MASK]);
  assign irq_oe_o = active;
  assign irq_o    = active & ctl_q[CB_POL];

  always_comb begin
    case (addr_i)
      REG_ALM_MIN: rdata_o = alm_min_q;
      REG_ALM_HR:  rdata_o = alm_hr_q;
      REG_ALM_DAY: rdata_o = {alm_day_q[3], 4'b0000, alm_day_q[2:0]};
      REG_WD_LO:   rdata_o = wd_lo_q;
      REG_WD_HI:   rdata_o = wd_hi_q;
      REG_CTRL:    rdata_o = {ctl_q, wd_flag, tod_flag};
      default:     rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/tdw_irq_checker.sv
module tdw_irq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic [2:0] addr_i,
  input logic       tick_100hz_i,
  input logic       irq_o,
  input logic       irq_oe_o,
  input logic       tod_flag,
  input logic       wd_flag,
  input logic       sel_wd,
  input logic       pulse_mode
);
  // R2: time-of-day flag only rises at a sampled tick
  a_r2_tod_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tod_flag) |-> $past(tick_100hz_i));

  // R6: watchdog flag only rises at a sampled tick
  a_r6_wd_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wd_flag) |-> $past(tick_100hz_i));

  a_r5_tod_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && addr_i <= 3'd2 && !tick_100hz_i) |=> !tod_flag);

  a_r7_wd_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && (addr_i == 3'd3 || addr_i == 3'd4)) |=> !wd_flag);

  a_r9_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_oe_o |-> (sel_wd ? wd_flag : tod_flag));

  a_r10_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_oe_o |-> !irq_o);

  a_r11_level_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_mode && wd_flag && !(sel_i && (addr_i == 3'd3 || addr_i == 3'd4)))
      |=> wd_flag);
endmodule

bind tod_wdog_irq tdw_irq_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sel_i        (sel_i),
  .addr_i       (addr_i),
  .tick_100hz_i (tick_100hz_i),
  .irq_o        (irq_o),
  .irq_oe_o     (irq_oe_o),
  .tod_flag     (tod_flag),
  .wd_flag      (wd_flag),
  .sel_wd       (ctl_q[6]),
  .pulse_mode   (ctl_q[4])
);

// File: tb/sim_tod_wdog_irq.sv
module sim_tod_wdog_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       t100 = 1'b0, t1k = 1'b0;
  logic [7:0] sec = 8'h00, mn = 8'h00, hr = 8'h00, day = 8'h01;
  logic       sel = 1'b0, wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, irq_oe;

  int n_tot = 0, n_fail = 0;

  always #10 clk = ~clk;

  tod_wdog_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_100hz_i(t100), .tick_1khz_i(t1k),
    .cur_sec_i(sec), .cur_min_i(mn), .cur_hr_i(hr), .cur_day_i(day),
    .sel_i(sel), .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .irq_oe_o(irq_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); t100 = 1'b1;
      @(negedge clk); t100 = 1'b0;
    end
  endtask

  task automatic ms_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); t1k = 1'b1;
      @(negedge clk); t1k = 1'b0;
    end
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [7:0] d);
    @(negedge clk); sec = s; mn = m; hr = h; day = d;
  endtask

  function automatic logic [7:0] pin();
    return {6'b0, irq_oe, irq};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pin", pin(), 8'h00);
    for (int a = 0; a < 6; a++) begin
      bus_rd(3'(a), d);
      check("R1 regs", d, 8'h00);
    end
    bus_wr(3'd2, 8'hFF);
    bus_rd(3'd2, d);
    check("R1 weekday byte", d, 8'h87);
  endtask

  task automatic t_full_match();
    logic [7:0] d;
    bus_wr(3'd0, 8'h30); bus_wr(3'd1, 8'h12); bus_wr(3'd2, 8'h03);
    set_time(8'h15, 8'h29, 8'h12, 8'h03);
    tick(1);
    bus_rd(3'd5, d); check("R2 no match", d, 8'h00);
    set_time(8'h16, 8'h30, 8'h12, 8'h03);
    @(negedge clk); t100 = 1'b1;
    @(negedge clk); t100 = 1'b0;
    check("R12 pin on tick edge", pin(), 8'h02);
    bus_rd(3'd5, d); check("R2 flag set", d, 8'h01);
    bus_rd(3'd0, d); check("R5 read alarm", d, 8'h30);
    bus_rd(3'd5, d); check("R5 cleared by read", d, 8'h00);
    check("R5 pin released", pin(), 8'h00);
    tick(2);
    bus_rd(3'd5, d); check("R2 no refire", d, 8'h00);
    set_time(8'h17, 8'h31, 8'h12, 8'h03); tick(1);
    set_time(8'h18, 8'h30, 8'h12, 8'h03); tick(1);
    bus_rd(3'd5, d); check("R2 refire after gap", d, 8'h01);
    bus_wr(3'd1, 8'h12);
    bus_rd(3'd5, d); check("R5 cleared by write", d, 8'h00);
  endtask

  task automatic t_masks();
    logic [7:0] d;
    set_time(8'h00, 8'h30, 8'h12, 8'h05);
    bus_wr(3'd2, 8'h83);
    tick(1);
    bus_rd(3'd5, d); check("R3 daily", d, 8'h01);
    set_time(8'h00, 8'h30, 8'h07, 8'h06);
    bus_wr(3'd1, 8'h92);
    tick(1);
    bus_rd(3'd5, d); check("R3 hourly", d, 8'h01);
    set_time(8'h00, 8'h31, 8'h07, 8'h06);
    bus_wr(3'd1, 8'h92);
    tick(1);
    bus_rd(3'd5, d); check("R3 hourly min mismatch", d, 8'h00);
  endtask

  task automatic t_minute();
    logic [7:0] d;
    bus_wr(3'd0, 8'hB0);
    set_time(8'h59, 8'h44, 8'h03, 8'h02);
    tick(1);
    bus_rd(3'd5, d); check("R4 sec 59", d, 8'h00);
    set_time(8'h00, 8'h45, 8'h03, 8'h02);
    tick(1);
    bus_rd(3'd5, d); check("R4 sec 00", d, 8'h01);
  endtask

  task automatic t_route();
    logic [7:0] d;
    bus_wr(3'd5, 8'h04);
    bus_rd(3'd5, d); check("R9 tod mask flag", d, 8'h05);
    check("R9 tod mask pin", pin(), 8'h00);
    bus_wr(3'd5, 8'h40);
    check("R9 wd selected", pin(), 8'h00);
    bus_wr(3'd5, 8'h20);
    check("R10 drive high", pin(), 8'h03);
    bus_wr(3'd5, 8'h00);
    check("R10 pull low", pin(), 8'h02);
    bus_rd(3'd2, d);
    check("R5 pin after clear", pin(), 8'h00);
  endtask

  task automatic t_wdog();
    logic [7:0] d;
    bus_wr(3'd5, 8'h48);
    bus_wr(3'd3, 8'h05); bus_wr(3'd4, 8'h00);
    tick(4);
    bus_rd(3'd5, d); check("R6 before expiry", d, 8'h48);
    tick(1);
    bus_rd(3'd5, d); check("R6 expiry", d, 8'h4A);
    check("R9 wd mask pin", pin(), 8'h00);
    bus_wr(3'd5, 8'h40);
    check("R9 wd pin", pin(), 8'h02);
    ms_tick(6); tick(2);
    bus_rd(3'd5, d); check("R11 level hold", d, 8'h42);
    bus_rd(3'd3, d); check("R6 read stored", d, 8'h05);
    bus_rd(3'd5, d); check("R7 read clears", d, 8'h40);
    bus_wr(3'd3, 8'h00); bus_wr(3'd4, 8'h01);
    tick(99);
    bus_rd(3'd5, d); check("R6 tick 99 of 100", d, 8'h40);
    tick(1);
    bus_rd(3'd5, d); check("R6 tick 100", d, 8'h42);
  endtask

  task automatic t_kick();
    logic [7:0] d;
    bus_wr(3'd3, 8'h05); bus_wr(3'd4, 8'h00);
    tick(3);
    bus_rd(3'd4, d); check("R7 read hi", d, 8'h00);
    tick(4);
    bus_rd(3'd5, d); check("R7 kick restarts", d, 8'h40);
    tick(1);
    bus_rd(3'd5, d); check("R7 expiry after kick", d, 8'h42);
  endtask

  task automatic t_disable();
    logic [7:0] d;
    bus_wr(3'd3, 8'h00); bus_wr(3'd4, 8'h00);
    tick(20);
    bus_rd(3'd5, d); check("R8 disabled", d, 8'h40);
  endtask

  task automatic t_pulse();
    logic [7:0] d;
    bus_wr(3'd5, 8'h70);
    bus_wr(3'd3, 8'h01);
    tick(1);
    check("R11 pulse start", pin(), 8'h03);
    ms_tick(3);
    check("R11 pulse held 3", pin(), 8'h03);
    ms_tick(1);
    check("R11 pulse released", pin(), 8'h00);
    bus_rd(3'd5, d); check("R11 flag cleared", d, 8'h70);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_tot++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_match();
    t_masks();
    t_minute();
    t_route();
    t_wdog();
    t_kick();
    t_disable();
    t_pulse();
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule